// File: doc/BRIEF.md
# Processor Status Word and Interrupt Gate

This block keeps the 16-bit processor status word and the exception table base of a small processor core. It also decides, cycle by cycle, whether a prioritized interrupt request may be taken. The sequencer writes the status word or the table base through one write port. Writes are filtered by the privilege flag the status word currently holds. The sequencer signals interrupt exception entry with a strobe and the accepted level, and it reloads a stacked status word on return from exception. The old status word is presented for one cycle so that a separate stacking engine can save it.

The interrupt gate compares the 3-bit request level against the mask field. Levels 1 to 6 must be strictly above the mask to be accepted. Level 7 ignores the mask but counts only on its rising edge. The block also forms the address of a table entry from the stored base and an 8-bit vector number. All pins are plain control and status signals. No data stream crosses the block, so no port carries a handshake and back-pressure does not apply.

Top module: `psw_ctrl`

## Requirements
- R1: The status word has trace flag at bit 15, supervisor flag at bit 13, master flag at bit 12, mask at bits 10:8, and condition codes in bits 4:0; bits 14, 11, 7, 6 and 5 always read 0.
- R2: A status write (`wr_en`=1, `wr_sel`=0) while the supervisor flag is 1 updates every implemented bit from `wr_data[15:0]`.
- R3: A status write while the supervisor flag is 0 changes only bits 4:0; bits 15:8 keep their value.
- R4: After reset, bits 15:8 of the status word read 0x27 (trace 0, supervisor 1, master 0, mask 7); the table base reads 0.
- R5: A request level L in 1..6 gives `irq_accept`=1 with `irq_accept_lvl`=L in the same cycle only when L > mask; level 0 never gives an accept.
- R6: Level 7 gives one accept on the cycle it first appears, regardless of the mask. It gives no further accept while the level stays 7, and it re-arms once the level has gone below 7.
- R7: On `exc_take`, the next status word has supervisor 1, trace 0, master 0, mask = `exc_level`, and the condition codes unchanged.
- R8: The cycle after `exc_take`, `saved_valid` is 1 and `saved_word` holds the status word from before entry; `saved_valid` is 0 the cycle after that unless entry repeats.
- R9: `rte_load` loads all implemented bits from `rte_word`, including the master flag; unimplemented bits stay 0.
- R10: A table base write (`wr_en`=1, `wr_sel`=1) stores `wr_data[31:20]` only while the supervisor flag is 1; bits 19:0 of `vbase` always read 0.
- R11: `vec_addr` equals `vbase` + 4 × `vec_num`, combinationally.
- R12: When several status updates coincide, `exc_take` wins over `rte_load`, which wins over a status write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | 0 = status word, 1 = table base |
| wr_data | input | 32 | Write data |
| irq_level | input | 3 | Pending interrupt request level, 0 = none |
| exc_take | input | 1 | Interrupt exception entry strobe |
| exc_level | input | 3 | Level accepted at entry |
| rte_load | input | 1 | Return-from-exception restore strobe |
| rte_word | input | 16 | Status word to restore |
| vec_num | input | 8 | Vector number |
| status_word | output | 16 | Current status word |
| t_flag | output | 1 | Trace flag |
| s_flag | output | 1 | Supervisor flag |
| m_flag | output | 1 | Master flag |
| int_mask | output | 3 | Interrupt mask |
| vbase | output | 32 | Table base, low 20 bits zero |
| irq_accept | output | 1 | Request may be taken |
| irq_accept_lvl | output | 3 | Level being accepted, 0 when none |
| vec_addr | output | 32 | Table entry address |
| saved_word | output | 16 | Status word from before the last entry |
| saved_valid | output | 1 | One-cycle pulse after entry |

## Verification
The gate is swept over every request level against a middle mask value of 3. This separates a strict compare from a greater-or-equal compare and shows that level 0 is never taken. Level 7 is driven with the mask at 7 in three ways: held for several cycles, dropped to 6 and raised again, and held after a drop. Together these separate edge detection from level detection and show whether re-arming works. Status writes are tried with all-ones and all-zeros data in both privilege modes, so that unimplemented bits and the protected upper byte show up. Coincident strobes tell the update priority apart.

// File: rtl/psw_pkg.sv
package psw_pkg;
  localparam int PSW_W  = 16;
  localparam int LVL_W  = 3;
  localparam int BIT_T  = 15;
  localparam int BIT_S  = 13;
  localparam int BIT_M  = 12;
  localparam int MASK_LO = 8;
  localparam logic [PSW_W-1:0] IMPL_BITS  = 16'hB71F;
  localparam logic [PSW_W-1:0] USER_BITS  = 16'h001F;
  localparam logic [PSW_W-1:0] RESET_WORD = 16'h2700;
  localparam logic [LVL_W-1:0] NMI_LVL    = 3'd7;
endpackage

// File: rtl/psw_reg.sv
module psw_reg
  import psw_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [PSW_W-1:0] wr_word,
  input  logic             exc_take,
  input  logic [LVL_W-1:0] exc_level,
  input  logic             rte_load,
  input  logic [PSW_W-1:0] rte_word,
  output logic [PSW_W-1:0] psw,
  output logic [PSW_W-1:0] saved_word,
  output logic             saved_valid
);
  logic [PSW_W-1:0] wmask;
  logic [PSW_W-1:0] entry_word;

  assign wmask = psw[BIT_S] ? IMPL_BITS : USER_BITS;

  always_comb begin
    entry_word = psw & IMPL_BITS;
    entry_word[BIT_T] = 1'b0;
    entry_word[BIT_S] = 1'b1;
    entry_word[BIT_M] = 1'b0;
    entry_word[MASK_LO +: LVL_W] = exc_level;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      psw         <= RESET_WORD;
      saved_word  <= '0;
      saved_valid <= 1'b0;
    end else begin
      saved_valid <= exc_take;
      if (exc_take) begin
        saved_word <= psw;
        psw        <= entry_word;
      end else if (rte_load) begin
        psw <= rte_word & IMPL_BITS;
      end else if (wr_en) begin
        psw <= (psw & ~wmask) | (wr_word & wmask);
      end
    end
  end
endmodule

// File: rtl/irq_gate.sv
module irq_gate
  import psw_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LVL_W-1:0] irq_level,
  input  logic [LVL_W-1:0] mask,
  output logic             accept,
  output logic [LVL_W-1:0] accept_lvl
);
  logic armed;
  logic is_nmi;
  logic maskable_ok;

  assign is_nmi      = (irq_level == NMI_LVL);
  assign maskable_ok = !is_nmi && (irq_level != '0) && (irq_level > mask);
  assign accept      = maskable_ok || (is_nmi && armed);
  assign accept_lvl  = accept ? irq_level : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) armed <= 1'b1;
    else        armed <= !is_nmi;
  end
endmodule

// File: rtl/vbase_reg.sv
module vbase_reg #(
  parameter int ADDR_W = 32,
  parameter int KEEP_LSB = 20,
  parameter int VEC_W = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       wr_en,
  input  logic [ADDR_W-KEEP_LSB-1:0] wr_hi,
  input  logic [VEC_W-1:0]           vec_num,
  output logic [ADDR_W-1:0]          vbase,
  output logic [ADDR_W-1:0]          vec_addr
);
  localparam int HI_W  = ADDR_W - KEEP_LSB;
  localparam int PAD_W = KEEP_LSB - VEC_W - 2;

  logic [HI_W-1:0] base_hi;

  always_ff @(posedge clk) begin
    if (!rst_n)     base_hi <= '0;
    else if (wr_en) base_hi <= wr_hi;
  end

  assign vbase    = {base_hi, {KEEP_LSB{1'b0}}};
  assign vec_addr = {base_hi, {PAD_W{1'b0}}, vec_num, 2'b00};
endmodule

// File: rtl/psw_ctrl.sv
module psw_ctrl
  import psw_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int KEEP_LSB = 20,
  parameter int VEC_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              wr_sel,
  input  logic [ADDR_W-1:0] wr_data,
  input  logic [2:0]        irq_level,
  input  logic              exc_take,
  input  logic [2:0]        exc_level,
  input  logic              rte_load,
  input  logic [15:0]       rte_word,
  input  logic [VEC_W-1:0]  vec_num,
  output logic [15:0]       status_word,
  output logic              t_flag,
  output logic              s_flag,
  output logic              m_flag,
  output logic [2:0]        int_mask,
  output logic [ADDR_W-1:0] vbase,
  output logic              irq_accept,
  output logic [2:0]        irq_accept_lvl,
  output logic [ADDR_W-1:0] vec_addr,
  output logic [15:0]       saved_word,
  output logic              saved_valid
);
  localparam int HI_W = ADDR_W - KEEP_LSB;

  logic wr_status;
  logic wr_base;

  assign wr_status = wr_en && !wr_sel;
  assign wr_base   = wr_en && wr_sel && s_flag;

  psw_reg u_psw (
    .clk(clk), .rst_n(rst_n),
    .wr_en(wr_status), .wr_word(wr_data[PSW_W-1:0]),
    .exc_take(exc_take), .exc_level(exc_level),
    .rte_load(rte_load), .rte_word(rte_word),
    .psw(status_word), .saved_word(saved_word), .saved_valid(saved_valid)
  );

  assign t_flag   = status_word[BIT_T];
  assign s_flag   = status_word[BIT_S];
  assign m_flag   = status_word[BIT_M];
  assign int_mask = status_word[MASK_LO +: LVL_W];

  irq_gate u_gate (
    .clk(clk), .rst_n(rst_n),
    .irq_level(irq_level), .mask(int_mask),
    .accept(irq_accept), .accept_lvl(irq_accept_lvl)
  );

  vbase_reg #(.ADDR_W(ADDR_W), .KEEP_LSB(KEEP_LSB), .VEC_W(VEC_W)) u_vb (
    .clk(clk), .rst_n(rst_n),
    .wr_en(wr_base), .wr_hi(wr_data[ADDR_W-1 -: HI_W]),
    .vec_num(vec_num), .vbase(vbase), .vec_addr(vec_addr)
  );
endmodule

// File: rtl/psw_ctrl_chk.sv
module psw_ctrl_chk #(
  parameter int ADDR_W = 32,
  parameter int VEC_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic              wr_sel,
  input logic [ADDR_W-1:0] wr_data,
  input logic [2:0]        irq_level,
  input logic              exc_take,
  input logic [2:0]        exc_level,
  input logic              rte_load,
  input logic [15:0]       rte_word,
  input logic [VEC_W-1:0]  vec_num,
  input logic [15:0]       status_word,
  input logic              t_flag,
  input logic              s_flag,
  input logic              m_flag,
  input logic [2:0]        int_mask,
  input logic [ADDR_W-1:0] vbase,
  input logic              irq_accept,
  input logic [2:0]        irq_accept_lvl,
  input logic [ADDR_W-1:0] vec_addr,
  input logic [15:0]       saved_word,
  input logic              saved_valid
);
  logic was7;
  always_ff @(posedge clk) begin
    if (!rst_n) was7 <= 1'b0;
    else        was7 <= (irq_level == 3'd7);
  end

  p_zero_bits_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (status_word & 16'h48E0) == 16'h0);

  p_user_upper_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_sel && !s_flag && !exc_take && !rte_load)
      |=> status_word[15:8] == $past(status_word[15:8]));

  p_mask_block_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_level != 3'd7 && irq_level <= int_mask) |-> !irq_accept);

  p_nmi_once_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_level == 3'd7 && was7) |-> !irq_accept);

  p_entry_r7: assert property (@(posedge clk) disable iff (!rst_n)
    exc_take |=> (s_flag && !t_flag && !m_flag && int_mask == $past(exc_level)));

  p_saved_r8: assert property (@(posedge clk) disable iff (!rst_n)
    exc_take |=> (saved_valid && saved_word == $past(status_word)));

  p_base_low_r10: assert property (@(posedge clk) disable iff (!rst_n)
    vbase[19:0] == 20'h0);

  p_base_guard_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_sel && !s_flag) |=> $stable(vbase));

  p_vaddr_r11: assert property (@(posedge clk) disable iff (!rst_n)
    vec_addr == vbase + ADDR_W'({vec_num, 2'b00}));

  p_acc_lvl_r5: assert property (@(posedge clk) disable iff (!rst_n)
    irq_accept |-> irq_accept_lvl == irq_level);

  logic unused_ok;
  assign unused_ok = ^{wr_data, rte_word, irq_accept_lvl};
endmodule

bind psw_ctrl psw_ctrl_chk #(.ADDR_W(ADDR_W), .VEC_W(VEC_W)) u_chk (.*);

// File: tb/psw_ctrl_bench.sv
module psw_ctrl_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr_en, wr_sel;
  logic [31:0] wr_data;
  logic [2:0]  irq_level;
  logic        exc_take;
  logic [2:0]  exc_level;
  logic        rte_load;
  logic [15:0] rte_word;
  logic [7:0]  vec_num;
  logic [15:0] status_word, saved_word;
  logic        t_flag, s_flag, m_flag, irq_accept, saved_valid;
  logic [2:0]  int_mask, irq_accept_lvl;
  logic [31:0] vbase, vec_addr;

  int n_run = 0;
  int n_fail = 0;

  always #5 clk = ~clk;

  psw_ctrl u_psw_ctrl (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic idle();
    wr_en = 0; wr_sel = 0; wr_data = '0; exc_take = 0; exc_level = 0;
    rte_load = 0; rte_word = '0;
  endtask

  // advance one clock; return at the following negedge
  task automatic step();
    @(posedge clk); @(negedge clk);
    idle();
    #1;
  endtask

  task automatic wr_status(input logic [15:0] d);
    wr_en = 1; wr_sel = 0; wr_data = {16'h0, d}; step();
  endtask

  task automatic wr_base(input logic [31:0] d);
    wr_en = 1; wr_sel = 1; wr_data = d; step();
  endtask

  task automatic restore(input logic [15:0] d);
    rte_load = 1; rte_word = d; step();
  endtask

  task automatic t_reset();
    chk("R4 upper byte", {24'h0, status_word[15:8]}, 32'h27);
    chk("R4 base", vbase, 32'h0);
    chk("R8 idle", {31'h0, saved_valid}, 32'h0);
  endtask

  task automatic t_sup_write();
    wr_status(16'hFFFF);
    chk("R2 all ones / R1 zeros", {16'h0, status_word}, 32'hB71F);
    wr_status(16'h2000);
    chk("R2 clear", {16'h0, status_word}, 32'h2000);
  endtask

  task automatic t_user_write();
    wr_status(16'h0000);
    chk("R2 drop to user", {31'h0, s_flag}, 32'h0);
    wr_status(16'hFFFF);
    chk("R3 user ones", {16'h0, status_word}, 32'h001F);
    wr_status(16'hFF00);
    chk("R3 user zeros", {16'h0, status_word}, 32'h0000);
    wr_base(32'hFFF00000);
    chk("R10 user base ignored", vbase, 32'h0);
    restore(16'h2000);
  endtask

  task automatic t_mask();
    wr_status(16'h2300);
    irq_level = 0; #1;
    chk("R5 level0", {28'h0, irq_accept, irq_accept_lvl}, 32'h0);
    for (int l = 1; l < 7; l++) begin
      irq_level = 3'(l); #1;
      chk("R5 accept", {31'h0, irq_accept}, (l > 3) ? 32'h1 : 32'h0);
      chk("R5 level", {29'h0, irq_accept_lvl}, (l > 3) ? 32'(l) : 32'h0);
    end
    irq_level = 0; step();
  endtask

  task automatic t_nmi();
    wr_status(16'h2700);
    irq_level = 0; step();
    irq_level = 7; #1;
    chk("R6 first edge", {28'h0, irq_accept, irq_accept_lvl}, 32'hF);
    for (int k = 0; k < 3; k++) begin
      step();
      chk("R6 held", {31'h0, irq_accept}, 32'h0);
    end
    irq_level = 6; #1;
    chk("R6 masked 6", {31'h0, irq_accept}, 32'h0);
    step();
    irq_level = 7; #1;
    chk("R6 re-armed", {31'h0, irq_accept}, 32'h1);
    step();
    chk("R6 held again", {31'h0, irq_accept}, 32'h0);
    irq_level = 0; step();
  endtask

  task automatic t_entry();
    wr_status(16'hB305);
    exc_take = 1; exc_level = 5; step();
    chk("R7 new word", {16'h0, status_word}, 32'h2505);
    chk("R8 saved", {16'h0, saved_word}, 32'hB305);
    chk("R8 pulse", {31'h0, saved_valid}, 32'h1);
    step();
    chk("R8 pulse ends", {31'h0, saved_valid}, 32'h0);
  endtask

  task automatic t_rte();
    restore(16'h1204);
    chk("R9 restore with M", {16'h0, status_word}, 32'h1204);
    restore(16'hFFFF);
    chk("R9 restore masked", {16'h0, status_word}, 32'hB71F);
  endtask

  task automatic t_base();
    wr_status(16'h2000);
    wr_base(32'hABCDE123);
    chk("R10 base", vbase, 32'hABC00000);
    vec_num = 8'h40; #1;
    chk("R11 addr 0x40", vec_addr, 32'hABC00100);
    vec_num = 8'hFF; #1;
    chk("R11 addr 0xFF", vec_addr, 32'hABC003FC);
  endtask

  task automatic t_priority();
    wr_status(16'h2000);
    exc_take = 1; exc_level = 4; rte_load = 1; rte_word = 16'h0000;
    wr_en = 1; wr_sel = 0; wr_data = 32'h0000_0000; step();
    chk("R12 entry wins", {16'h0, status_word}, 32'h2400);
    rte_load = 1; rte_word = 16'h2101; wr_en = 1; wr_sel = 0; wr_data = 32'h2602; step();
    chk("R12 restore wins", {16'h0, status_word}, 32'h2101);
  endtask

  initial begin
    #2_000_000;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    idle();
    irq_level = 0; vec_num = 0;
    rst_n = 0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1; #1;
    t_reset();
    t_sup_write();
    t_user_write();
    t_mask();
    t_nmi();
    t_entry();
    t_rte();
    t_base();
    t_priority();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule